// File: doc/BRIEF.md
# E1 Signaling Multiframe Aligner and ABCD Extractor

This block sits after basic frame alignment on an E1 receive path. Once per basic frame it takes the time slot 16 octet, qualified by a one-cycle frame strobe. From these octets it finds and tracks the 16-frame channel associated signaling multiframe. That boundary is tracked on its own and has no link to any CRC-4 multiframe.

While the block is aligned, it splits each signaling octet into two ABCD nibbles. It writes them into a 30-entry per-channel store, which a combinational read port indexed by channel number gives access to.

The block also builds the frame-0 time slot 16 octet for the transmit direction. That octet carries the 0000 alignment nibble, the spare bits and the Y alarm bit. The Y bit reports this receiver's own alignment state back to the far end.

Top module: `cas_mf_sync`

## Requirements
- R1: After reset the block is out of alignment (`mf_sync_o`=0, `y_bit_o`=1), the multiframe position is 0 and every stored channel value reads 0000.
- R2: `tx_fr0_o`, written MSB first as bits 1 to 8, carries 0000 in bits 1 to 4, Y in bit 6 and the spare value 1 in bits 5, 7 and 8. Y is 0 while aligned and 1 otherwise, which gives 0x0B aligned and 0x0F not aligned.
- R3: Out of alignment, an octet whose upper nibble is 0000 marks a candidate frame 0 and sets the position to 0. Alignment is declared on the strobe 16 frames later if that octet's upper nibble is also 0000. The position then reads 0.
- R4: If a 0000 upper nibble arrives at positions 1 to 15 while a candidate is pending, that frame becomes the new candidate frame 0 and the position returns to 0. An octet without 0000 at the expected frame 0 of a candidate abandons the search.
- R5: The 4-bit position advances by one on each frame strobe, wrapping from 15 to 0. It does not change on cycles without a strobe.
- R6: While aligned, one expected frame 0 without 0000 is tolerated. Two consecutive such frames drop alignment on the second one's strobe.
- R7: While aligned, the octet at position n (1 to 15) stores its upper nibble as channel n and its lower nibble as channel n+15.
- R8: While not aligned, no channel value changes, so the values written last stay readable.
- R9: A read of channel 0 or of a channel above 30 returns 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_stb_i | input | 1 | One-cycle strobe, time slot 16 octet valid |
| ts16_i | input | 8 | Received time slot 16 octet, bit 1 in MSB |
| rd_ch_i | input | 5 | Channel number to read, 1 to 30 |
| rd_abcd_o | output | 4 | ABCD value of the selected channel |
| mf_sync_o | output | 1 | Signaling multiframe alignment held |
| y_bit_o | output | 1 | Y bit to transmit, 1 while not aligned |
| tx_fr0_o | output | 8 | Transmit frame-0 time slot 16 octet |
| mf_pos_o | output | 4 | Position of the last received frame in the multiframe |

## Verification
The signaling payload nibbles are made nonzero in the upper half and vary per multiframe and per frame. A full 30-channel sweep after each multiframe therefore tells a correct n / n+15 pairing apart from a swapped or shifted one. It also tells a stale value apart from a fresh one.

Alignment is exercised with three kinds of input. A clean pattern checks acquisition. A premature 0000 nibble shows that the candidate restarts rather than locking 16 frames after the first 0000. A single bad frame 0 followed by a double miss separates the tolerated miss from true loss.

Signaling multiframes sent after loss show that the store is frozen.

// File: rtl/cas_mf_pkg.sv
// Shared constants and types for the signaling multiframe aligner.
// Assumes a 16-frame multiframe carrying two channels per signaling frame.
package cas_mf_pkg;
    localparam int FR_PER_MF  = 16;
    localparam int POS_W      = $clog2(FR_PER_MF);
    localparam int NIB_W      = 4;
    localparam int OCT_W      = 2 * NIB_W;
    localparam int SIG_FRAMES = FR_PER_MF - 1;
    localparam int NUM_CH     = 2 * SIG_FRAMES;
    localparam int CH_W       = $clog2(NUM_CH + 2);
    localparam int MISS_LIMIT = 2;
    localparam int MISS_W     = $clog2(MISS_LIMIT + 1);

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_SYNC    = 2'd2
    } mf_state_e;
endpackage

// File: rtl/cas_mf_align.sv
// Multiframe alignment state machine and position counter.
// Does: hunts for a 0000 upper nibble, confirms it 16 frames later, tracks
// alignment with a miss counter and issues write enables for signaling frames.
// Assumes: strobe_i is high for exactly one cycle per basic frame.
module cas_mf_align
    import cas_mf_pkg::*;
#(
    parameter int P_POS_W      = POS_W,
    parameter int P_NIB_W      = NIB_W,
    parameter int P_MISS_LIMIT = MISS_LIMIT,
    parameter int P_MISS_W     = MISS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe_i,
    input  logic [P_NIB_W-1:0]   upper_i,
    output logic                 sync_o,
    output logic [P_POS_W-1:0]   pos_o,
    output logic                 wr_en_o,
    output logic [P_POS_W-1:0]   wr_pos_o
);
    mf_state_e             state_q, state_d;
    logic [P_POS_W-1:0]    pos_q, pos_d, pos_inc;
    logic [P_MISS_W-1:0]   miss_q, miss_d;
    logic                  upper_zero;

    assign upper_zero = (upper_i == '0);
    assign pos_inc    = pos_q + P_POS_W'(1);

    // Next-state, position and write decision for the current strobe.
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        miss_d  = miss_q;
        wr_en_o = 1'b0;
        if (strobe_i) begin
            pos_d = pos_inc;
            unique case (state_q)
                ST_HUNT: begin
                    if (upper_zero) begin
                        state_d = ST_CONFIRM;
                        pos_d   = '0;
                    end
                end
                ST_CONFIRM: begin
                    if (pos_inc == '0) begin
                        state_d = upper_zero ? ST_SYNC : ST_HUNT;
                        miss_d  = '0;
                    end else if (upper_zero) begin
                        pos_d = '0;
                    end
                end
                ST_SYNC: begin
                    if (pos_inc == '0) begin
                        if (upper_zero) begin
                            miss_d = '0;
                        end else if (miss_q == P_MISS_W'(P_MISS_LIMIT - 1)) begin
                            state_d = ST_HUNT;
                            miss_d  = '0;
                        end else begin
                            miss_d = miss_q + P_MISS_W'(1);
                        end
                    end else begin
                        wr_en_o = 1'b1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State, position and miss count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            miss_q  <= miss_d;
        end
    end

    assign sync_o   = (state_q == ST_SYNC);
    assign pos_o    = pos_q;
    assign wr_pos_o = pos_inc;
endmodule

// File: rtl/cas_sig_store.sv
// Per-channel ABCD store with a combinational read port.
// Does: writes the upper nibble to channel n and the lower to n+HALF when
// frame n is written; reads return 0 for channel numbers out of range.
// Assumes: wr_en_i is only raised for positions 1 to HALF.
module cas_sig_store
    import cas_mf_pkg::*;
#(
    parameter int P_NUM_CH = NUM_CH,
    parameter int P_NIB_W  = NIB_W,
    parameter int P_POS_W  = POS_W,
    parameter int P_CH_W   = CH_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [P_POS_W-1:0]            wr_pos_i,
    input  logic [P_NIB_W-1:0]            upper_i,
    input  logic [P_NIB_W-1:0]            lower_i,
    input  logic [P_CH_W-1:0]             rd_ch_i,
    output logic [P_NIB_W-1:0]            rd_abcd_o,
    output logic [P_NUM_CH*P_NIB_W-1:0]   flat_o
);
    localparam int HALF = P_NUM_CH / 2;

    logic [P_NIB_W-1:0] ent_q [P_NUM_CH];
    logic [P_CH_W-1:0]  rd_idx;
    logic               rd_ok;

    // Frame position that carries a given zero-based channel slot.
    function automatic logic [P_POS_W-1:0] frame_of(input int slot);
        return (slot < HALF) ? P_POS_W'(slot + 1) : P_POS_W'(slot + 1 - HALF);
    endfunction

    // Channel entry update on signaling frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < P_NUM_CH; c++) ent_q[c] <= '0;
        end else if (wr_en_i) begin
            for (int c = 0; c < P_NUM_CH; c++) begin
                if (wr_pos_i == frame_of(c)) ent_q[c] <= (c < HALF) ? upper_i : lower_i;
            end
        end
    end

    // Range check and channel read.
    assign rd_ok  = (rd_ch_i != '0) && (rd_ch_i <= P_CH_W'(P_NUM_CH));
    assign rd_idx = rd_ch_i - P_CH_W'(1);

    always_comb begin
        rd_abcd_o = '0;
        if (rd_ok) begin
            for (int c = 0; c < P_NUM_CH; c++) begin
                if (rd_idx == P_CH_W'(c)) rd_abcd_o = ent_q[c];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < P_NUM_CH; g++) begin : g_flat
            assign flat_o[g*P_NIB_W +: P_NIB_W] = ent_q[g];
        end
    endgenerate
endmodule

// File: rtl/cas_fr0_tx.sv
// Builds the transmit frame-0 time slot 16 octet.
// Does: 0000 alignment nibble, spare bits from a parameter, Y from sync.
// Assumes: bit 1 of the line octet is the MSB of the vector.
module cas_fr0_tx
    import cas_mf_pkg::*;
#(
    parameter int         P_OCT_W = OCT_W,
    parameter logic [2:0] P_SPARE = 3'b111
) (
    input  logic               sync_i,
    output logic               y_o,
    output logic [P_OCT_W-1:0] octet_o
);
    // Y alarm follows the receive alignment state.
    assign y_o     = ~sync_i;
    // Octet layout: 0000, X, Y, X, X.
    assign octet_o = {4'b0000, P_SPARE[2], y_o, P_SPARE[1:0]};
endmodule

// File: rtl/cas_mf_sync.sv
// Top: signaling multiframe aligner, ABCD extractor and frame-0 builder.
// Assumes frame alignment is done upstream and one strobe per basic frame.
module cas_mf_sync
    import cas_mf_pkg::*;
#(
    parameter logic [2:0] SPARE_X = 3'b111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_stb_i,
    input  logic [7:0]       ts16_i,
    input  logic [4:0]       rd_ch_i,
    output logic [3:0]       rd_abcd_o,
    output logic             mf_sync_o,
    output logic             y_bit_o,
    output logic [7:0]       tx_fr0_o,
    output logic [3:0]       mf_pos_o
);
    logic                      wr_en;
    logic [POS_W-1:0]          wr_pos;
    logic [NUM_CH*NIB_W-1:0]   store_flat;

    cas_mf_align u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (fr_stb_i),
        .upper_i  (ts16_i[OCT_W-1:NIB_W]),
        .sync_o   (mf_sync_o),
        .pos_o    (mf_pos_o),
        .wr_en_o  (wr_en),
        .wr_pos_o (wr_pos)
    );

    cas_sig_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_pos_i  (wr_pos),
        .upper_i   (ts16_i[OCT_W-1:NIB_W]),
        .lower_i   (ts16_i[NIB_W-1:0]),
        .rd_ch_i   (rd_ch_i),
        .rd_abcd_o (rd_abcd_o),
        .flat_o    (store_flat)
    );

    cas_fr0_tx #(.P_SPARE(SPARE_X)) u_tx (
        .sync_i  (mf_sync_o),
        .y_o     (y_bit_o),
        .octet_o (tx_fr0_o)
    );
endmodule

// File: rtl/cas_mf_sync_chk.sv
// Checker for cas_mf_sync, attached by bind; observes ports and store contents.
module cas_mf_sync_chk
    import cas_mf_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stb,
    input logic                     sync,
    input logic                     y,
    input logic [7:0]               tx,
    input logic [3:0]               pos,
    input logic [NUM_CH*NIB_W-1:0]  store
);
    a_r2_fr0_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx[7:4] == 4'b0000) && (tx[2] == !sync) && (y == !sync));

    a_r3_lock_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> (pos == 4'd0) && $past(stb));

    a_r5_step_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sync) |=> (pos == $past(pos) + 4'd1));

    a_r5_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(pos) && $stable(sync));

    a_r6_loss_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> (pos == 4'd0));

    a_r8_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(store));
endmodule

bind cas_mf_sync cas_mf_sync_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (fr_stb_i),
    .sync  (mf_sync_o),
    .y     (y_bit_o),
    .tx    (tx_fr0_o),
    .pos   (mf_pos_o),
    .store (store_flat)
);

// File: tb/cas_mf_sync_tb_top.sv
module cas_mf_sync_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fr_stb_i = 1'b0;
    logic [7:0] ts16_i = 8'hFF;
    logic [4:0] rd_ch_i = 5'd0;
    logic [3:0] rd_abcd_o;
    logic       mf_sync_o;
    logic       y_bit_o;
    logic [7:0] tx_fr0_o;
    logic [3:0] mf_pos_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [3:0] exp_ch [1:30];

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_mf_sync dut_i (
        .clk(clk), .rst_n(rst_n), .fr_stb_i(fr_stb_i), .ts16_i(ts16_i),
        .rd_ch_i(rd_ch_i), .rd_abcd_o(rd_abcd_o), .mf_sync_o(mf_sync_o),
        .y_bit_o(y_bit_o), .tx_fr0_o(tx_fr0_o), .mf_pos_o(mf_pos_o)
    );

    function automatic logic [3:0] up_nib(int k, int n);
        return 4'(1 + ((n + k) % 15));
    endfunction
    function automatic logic [3:0] lo_nib(int k, int n);
        return 4'((n * 7 + k * 3) % 16);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One strobed octet; returns at the next falling edge, after the update.
    task automatic send(logic [7:0] oct);
        @(negedge clk);
        fr_stb_i = 1'b1;
        ts16_i   = oct;
        @(negedge clk);
        fr_stb_i = 1'b0;
        ts16_i   = 8'hA5;
    endtask

    // Frames 1..15 of multiframe k; optionally the model records them.
    task automatic send_sig(int k, bit upd, bit chk_pos);
        for (int n = 1; n <= 15; n++) begin
            send({up_nib(k, n), lo_nib(k, n)});
            if (chk_pos) chk("R5 position step", mf_pos_o, n);
            if (upd) begin
                exp_ch[n]      = up_nib(k, n);
                exp_ch[n + 15] = lo_nib(k, n);
            end
        end
    endtask

    task automatic sweep(string tag);
        for (int c = 1; c <= 30; c++) begin
            rd_ch_i = 5'(c);
            #1;
            chk(tag, rd_abcd_o, exp_ch[c]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 1; c <= 30; c++) exp_ch[c] = 4'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sync", mf_sync_o, 0);
        chk("R1 y", y_bit_o, 1);
        chk("R1 pos", mf_pos_o, 0);
        chk("R2 tx unaligned", tx_fr0_o, 8'h0F);
        sweep("R1 store zero");

        // R5: idle cycles without strobe change nothing
        ts16_i = 8'h00;
        repeat (3) @(negedge clk);
        chk("R5 no strobe pos", mf_pos_o, 0);
        chk("R5 no strobe sync", mf_sync_o, 0);

        // R3 acquisition after noise
        for (int i = 0; i < 5; i++) send(8'h7C);
        chk("R3 noise no sync", mf_sync_o, 0);
        send(8'h0B);
        chk("R3 candidate pos", mf_pos_o, 0);
        chk("R3 not yet", mf_sync_o, 0);
        send_sig(0, 0, 1);
        chk("R3 not before second", mf_sync_o, 0);
        sweep("R8 no write while hunting");
        send(8'h0B);
        chk("R3 acquired", mf_sync_o, 1);
        chk("R3 pos zero", mf_pos_o, 0);
        chk("R2 y aligned", y_bit_o, 0);
        chk("R2 tx aligned", tx_fr0_o, 8'h0B);

        // R7 mapping over several multiframes
        for (int k = 1; k <= 3; k++) begin
            send_sig(k, 1, 1);
            sweep("R7 channel pairing");
            send(8'h0B);
            chk("R5 wrap", mf_pos_o, 0);
            chk("R6 stay aligned", mf_sync_o, 1);
        end

        // R6 single miss tolerated
        send_sig(4, 1, 0);
        send(8'h5B);
        chk("R6 single miss tolerated", mf_sync_o, 1);
        send_sig(5, 1, 0);
        sweep("R7 after single miss");
        send(8'h0B);
        chk("R6 recovered", mf_sync_o, 1);
        // R6 double miss
        send_sig(6, 1, 0);
        send(8'h9B);
        chk("R6 first miss", mf_sync_o, 1);
        send_sig(7, 1, 0);
        send(8'hFB);
        chk("R6 lost on second miss", mf_sync_o, 0);
        chk("R2 y after loss", y_bit_o, 1);
        chk("R2 tx after loss", tx_fr0_o, 8'h0F);
        // R8 frozen store
        send_sig(8, 0, 0);
        chk("R8 still hunting", mf_sync_o, 0);
        sweep("R8 store frozen");

        // R9 out-of-range reads
        rd_ch_i = 5'd0;  #1; chk("R9 channel 0", rd_abcd_o, 0);
        rd_ch_i = 5'd31; #1; chk("R9 channel 31", rd_abcd_o, 0);

        // R4 premature 0000 restarts the candidate
        send(8'h0F);
        chk("R4 candidate", mf_pos_o, 0);
        for (int i = 0; i < 5; i++) send(8'h3C);
        send(8'h0F);
        chk("R4 restart pos", mf_pos_o, 0);
        for (int i = 0; i < 10; i++) send(8'h3C);
        send(8'h0F);
        chk("R4 no lock on old spacing", mf_sync_o, 0);
        chk("R4 restart again", mf_pos_o, 0);
        for (int i = 0; i < 15; i++) send(8'h3C);
        send(8'h0F);
        chk("R4 lock on new spacing", mf_sync_o, 1);
        // R4 abandoned candidate
        send(8'hFF); send(8'hFF);
        for (int i = 0; i < 30; i++) send(8'h3C);
        send(8'hFF);
        chk("R6 lost again", mf_sync_o, 0);
        send(8'h0F);
        for (int i = 0; i < 15; i++) send(8'h3C);
        send(8'h3C);
        chk("R4 abandoned", mf_sync_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule